// File: doc/BRIEF.md
# Resizer Step and Filter Bank Calculator

This block turns a resizer's input size (the cropped picture) and output size (the scaled picture) into the settings the resizer needs for each axis. The settings are a fixed-point step increment with 4 integer and 20 fractional bits, and the index of the interpolation filter coefficient bank that suits the scaling ratio. The horizontal axis uses the widths and the vertical axis uses the heights, and the two axes are worked out independently of each other. The block also reports whether the scaler can be skipped entirely because the input and output sizes are the same.

A caller places the four sizes on the inputs and pulses `start`. Four restoring dividers run side by side, each producing one quotient bit per cycle. Two of them form the step increments and two form the thousandths-scaled output/input ratios. Each ratio is then matched against a parameterised table of eight inclusive ranges. When the results are registered, `done` pulses for one cycle. If any size is zero, the request is refused: `done` and `err` pulse together on the next cycle and the previous results stay in place.

Top module: `scale_cfg_calc`

## Requirements
- R1: After reset, `done`, `err`, `bypass`, `hMiss` and `vMiss` are 0, and `hStep`, `vStep`, `hBank` and `vBank` are 0.
- R2: `hStep` equals floor(inW * 2^20 / outW) and `vStep` equals floor(inH * 2^20 / outH). Both are Q4.20 values.
- R3: When the exact step quotient is larger than 2^24-1, the step output saturates to 2^24-1 (0xFFFFFF).
- R4: The bank ratio is floor(out * 1000 / in) for each axis. The bank is the lowest table index i for which LO[i] <= ratio <= HI[i], with both bounds inclusive. The default table is LO = {900,800,700,600,500,400,300,125} and HI = {1000,900,799,699,599,499,399,299} for indices 0 to 7, so index 0 wins on the overlap at ratio 900.
- R5: When the ratio of an axis falls inside no range, that axis's bank is 0 and its miss flag (`hMiss` or `vMiss`) is 1. Otherwise the miss flag is 0.
- R6: `bypass` is 1 exactly when inW == outW and inH == outH for the accepted request.
- R7: For a valid request, `done` is high for exactly one cycle, and it rises DIV_W+1 clock edges after the edge that samples `start` (35 edges with the default parameters). All outputs are updated on the same edge.
- R8: If any of the four sizes is 0 when `start` is sampled, `done` and `err` are both high in the cycle after that edge, and all result outputs keep their previous values.
- R9: A `start` raised while a computation is running is ignored. Changes to the size inputs after the accepted `start` do not affect that computation's results, and no extra `done` is produced.
- R10: The horizontal results depend only on the widths and the vertical results depend only on the heights, so the two axes may select different banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; sizes are sampled with it |
| inW | input | SIZE_W | Input (crop) width |
| inH | input | SIZE_W | Input (crop) height |
| outW | input | SIZE_W | Output (scale) width |
| outH | input | SIZE_W | Output (scale) height |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with `done` when a request is refused for a zero size |
| hStep | output | INT_W+FRAC_W | Horizontal Q4.20 step increment |
| vStep | output | INT_W+FRAC_W | Vertical Q4.20 step increment |
| hBank | output | BANK_W | Horizontal coefficient bank |
| vBank | output | BANK_W | Vertical coefficient bank |
| hMiss | output | 1 | Horizontal ratio matched no range |
| vMiss | output | 1 | Vertical ratio matched no range |
| bypass | output | 1 | Input and output sizes are equal on both axes |

## Verification
Every cycle, the assertions check the following. Each divider's quotient and remainder must rebuild the held dividend exactly, with a remainder below the divisor. A divider never starts on a zero divisor or while busy. `done` never lasts more than one cycle, and `err` never appears without it. A refused request leaves every result register untouched, and a miss flag always comes with bank 0. The bench scenarios are the only place where the ratio tables themselves are shown to hold: the inclusive edges at 125, 800 and 900 and the first-match priority, along with step saturation, the exact latency of `done`, and the rule that a mid-run `start` and later input changes are ignored.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int NBANK  = 8;
  localparam int BANK_W = $clog2(NBANK);

  typedef int bound_t [NBANK];

  // Inclusive ratio ranges in thousandths; lower index wins on overlap.
  localparam bound_t DEF_LO = '{900, 800, 700, 600, 500, 400, 300, 125};
  localparam bound_t DEF_HI = '{1000, 900, 799, 699, 599, 499, 399, 299};

  typedef struct packed {
    logic go;       // load operands and launch the dividers
    logic capture;  // register the finished results
    logic abort;    // refused request, results must hold
  } ctlStrobe_t;
endpackage

// File: rtl/scl_div.sv
module scl_div #(
  parameter int DIVD_W = 34,
  parameter int DIVS_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [DIVD_W-1:0] dividend,
  input  logic [DIVS_W-1:0] divisor,
  output logic              busy,
  output logic [DIVD_W-1:0] quotient
);
  localparam int CNT_W  = $clog2(DIVD_W + 1);
  localparam int PROD_W = DIVD_W + DIVS_W;

  logic [DIVS_W-1:0] dvs;
  logic [DIVS_W-1:0] rem;
  logic [DIVD_W-1:0] quo;
  logic [DIVD_W-1:0] held;
  logic [CNT_W-1:0]  cnt;
  logic [DIVS_W:0]   trial;
  logic [DIVS_W:0]   diff;
  logic              fits;

  assign trial = {rem, quo[DIVD_W-1]};
  assign diff  = trial - {1'b0, dvs};
  assign fits  = trial >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvs  <= '0;
      rem  <= '0;
      quo  <= '0;
      held <= '0;
      cnt  <= '0;
    end else if (go) begin
      dvs  <= divisor;
      rem  <= '0;
      quo  <= dividend;
      held <= dividend;
      cnt  <= CNT_W'(DIVD_W);
    end else if (cnt != '0) begin
      rem <= fits ? diff[DIVS_W-1:0] : trial[DIVS_W-1:0];
      quo <= {quo[DIVD_W-2:0], fits};
      cnt <= cnt - 1'b1;
    end
  end

  assign busy     = (cnt != '0);
  assign quotient = quo;

  // R2
  div_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_W'(1) && !go) |=>
      ((PROD_W'(quo) * PROD_W'(dvs) + PROD_W'(rem)) == PROD_W'(held)));

  // R2
  div_rem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_W'(1) && !go) |=> (rem < dvs));

  // R8
  div_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    go |-> (divisor != '0));
endmodule

// File: rtl/scl_bank.sv
module scl_bank
  import scl_pkg::*;
#(
  parameter int     DIVD_W   = 34,
  parameter bound_t RANGE_LO = DEF_LO,
  parameter bound_t RANGE_HI = DEF_HI
) (
  input  logic [DIVD_W-1:0] ratio,
  output logic [BANK_W-1:0] bank,
  output logic              miss
);
  logic [NBANK-1:0] hit;

  for (genvar i = 0; i < NBANK; i++) begin : g_range
    localparam logic [DIVD_W-1:0] LO = DIVD_W'(RANGE_LO[i]);
    localparam logic [DIVD_W-1:0] HI = DIVD_W'(RANGE_HI[i]);
    assign hit[i] = (ratio >= LO) && (ratio <= HI);
  end

  always_comb begin
    bank = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (hit[i]) bank = BANK_W'(i);
    end
  end

  assign miss = ~|hit;
endmodule

// File: rtl/scl_datapath.sv
module scl_datapath
  import scl_pkg::*;
#(
  parameter int     SIZE_W      = 14,
  parameter int     FRAC_W      = 20,
  parameter int     INT_W       = 4,
  parameter int     RATIO_SCALE = 1000,
  parameter bound_t RANGE_LO    = DEF_LO,
  parameter bound_t RANGE_HI    = DEF_HI,
  localparam int    STEP_W      = INT_W + FRAC_W,
  localparam int    DIV_W       = SIZE_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [SIZE_W-1:0] inW,
  input  logic [SIZE_W-1:0] inH,
  input  logic [SIZE_W-1:0] outW,
  input  logic [SIZE_W-1:0] outH,
  output logic              divBusy,
  output logic [STEP_W-1:0] hStep,
  output logic [STEP_W-1:0] vStep,
  output logic [BANK_W-1:0] hBank,
  output logic [BANK_W-1:0] vBank,
  output logic              hMiss,
  output logic              vMiss,
  output logic              bypass
);
  logic [SIZE_W-1:0] inSz  [2];
  logic [SIZE_W-1:0] outSz [2];
  logic [SIZE_W-1:0] latIn [2];
  logic [SIZE_W-1:0] latOut[2];
  logic [STEP_W-1:0] stepR [2];
  logic [BANK_W-1:0] bankR [2];
  logic              missR [2];
  logic [3:0]        busyV;

  assign inSz[0]  = inW;
  assign inSz[1]  = inH;
  assign outSz[0] = outW;
  assign outSz[1] = outH;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic [DIV_W-1:0]  stepQ;
    logic [DIV_W-1:0]  ratioQ;
    logic [STEP_W-1:0] stepSat;
    logic [BANK_W-1:0] bankSel;
    logic              missSel;

    scl_div #(.DIVD_W(DIV_W), .DIVS_W(SIZE_W)) u_stepDiv (
      .clk      (clk),
      .rstN     (rstN),
      .go       (strobe.go),
      .dividend ({inSz[a], FRAC_W'(0)}),
      .divisor  (outSz[a]),
      .busy     (busyV[2*a]),
      .quotient (stepQ)
    );

    scl_div #(.DIVD_W(DIV_W), .DIVS_W(SIZE_W)) u_ratioDiv (
      .clk      (clk),
      .rstN     (rstN),
      .go       (strobe.go),
      .dividend (DIV_W'(outSz[a]) * DIV_W'(RATIO_SCALE)),
      .divisor  (inSz[a]),
      .busy     (busyV[2*a+1]),
      .quotient (ratioQ)
    );

    scl_bank #(.DIVD_W(DIV_W), .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)) u_bank (
      .ratio (ratioQ),
      .bank  (bankSel),
      .miss  (missSel)
    );

    assign stepSat = (|stepQ[DIV_W-1:STEP_W]) ? '1 : stepQ[STEP_W-1:0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latIn[a]  <= '0;
        latOut[a] <= '0;
        stepR[a]  <= '0;
        bankR[a]  <= '0;
        missR[a]  <= 1'b0;
      end else begin
        if (strobe.go) begin
          latIn[a]  <= inSz[a];
          latOut[a] <= outSz[a];
        end
        if (strobe.capture) begin
          stepR[a] <= stepSat;
          bankR[a] <= bankSel;
          missR[a] <= missSel;
        end
      end
    end

    // R5
    miss_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
      missR[a] |-> (bankR[a] == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bypass <= 1'b0;
    else if (strobe.capture)
      bypass <= (latIn[0] == latOut[0]) && (latIn[1] == latOut[1]);
  end

  assign divBusy = |busyV;
  assign hStep   = stepR[0];
  assign vStep   = stepR[1];
  assign hBank   = bankR[0];
  assign vBank   = bankR[1];
  assign hMiss   = missR[0];
  assign vMiss   = missR[1];

  // R8
  hold_on_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> ($stable(stepR[0]) && $stable(stepR[1]) &&
                      $stable(bankR[0]) && $stable(bankR[1]) &&
                      $stable(missR[0]) && $stable(missR[1]) && $stable(bypass)));
endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       zeroSz,
  input  logic       divBusy,
  output ctlStrobe_t strobe,
  output logic       done,
  output logic       err
);
  typedef enum logic {ST_IDLE, ST_RUN} ctlState_e;
  ctlState_e state;

  always_comb begin
    strobe         = '0;
    strobe.go      = (state == ST_IDLE) && start && !zeroSz;
    strobe.abort   = (state == ST_IDLE) && start && zeroSz;
    strobe.capture = (state == ST_RUN) && !divBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= strobe.capture || strobe.abort;
      err  <= strobe.abort;
      if (strobe.go) state <= ST_RUN;
      else if (strobe.capture) state <= ST_IDLE;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  err_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R9
  go_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.go |-> !divBusy);
endmodule

// File: rtl/scale_cfg_calc.sv
module scale_cfg_calc
  import scl_pkg::*;
#(
  parameter int     SIZE_W      = 14,
  parameter int     FRAC_W      = 20,
  parameter int     INT_W       = 4,
  parameter int     RATIO_SCALE = 1000,
  parameter bound_t RANGE_LO    = DEF_LO,
  parameter bound_t RANGE_HI    = DEF_HI,
  localparam int    STEP_W      = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SIZE_W-1:0] inW,
  input  logic [SIZE_W-1:0] inH,
  input  logic [SIZE_W-1:0] outW,
  input  logic [SIZE_W-1:0] outH,
  output logic              done,
  output logic              err,
  output logic [STEP_W-1:0] hStep,
  output logic [STEP_W-1:0] vStep,
  output logic [BANK_W-1:0] hBank,
  output logic [BANK_W-1:0] vBank,
  output logic              hMiss,
  output logic              vMiss,
  output logic              bypass
);
  ctlStrobe_t strobe;
  logic       divBusy;
  logic       zeroSz;

  assign zeroSz = (inW == '0) || (inH == '0) || (outW == '0) || (outH == '0);

  scl_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .zeroSz  (zeroSz),
    .divBusy (divBusy),
    .strobe  (strobe),
    .done    (done),
    .err     (err)
  );

  scl_datapath #(
    .SIZE_W(SIZE_W), .FRAC_W(FRAC_W), .INT_W(INT_W),
    .RATIO_SCALE(RATIO_SCALE), .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inW     (inW),
    .inH     (inH),
    .outW    (outW),
    .outH    (outH),
    .divBusy (divBusy),
    .hStep   (hStep),
    .vStep   (vStep),
    .hBank   (hBank),
    .vBank   (vBank),
    .hMiss   (hMiss),
    .vMiss   (vMiss),
    .bypass  (bypass)
  );
endmodule

// File: tb/tb_scale_cfg_calc.sv
module tb_scale_cfg_calc;
  localparam int SW  = 14;
  localparam int LAT = 35;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] inW = '0, inH = '0, outW = '0, outH = '0;
  logic done, err, hMiss, vMiss, bypass;
  logic [23:0] hStep, vStep;
  logic [2:0] hBank, vBank;

  int errors = 0;
  int checks = 0;
  int doneCount = 0;
  bit finished = 0;

  longint expHS, expVS;
  int expHB, expVB;
  bit expHM, expVM, expBy;

  int tLo[8] = '{900, 800, 700, 600, 500, 400, 300, 125};
  int tHi[8] = '{1000, 900, 799, 699, 599, 499, 399, 299};

  always #2 clk = ~clk;

  always @(negedge clk) if (done) doneCount++;

  scale_cfg_calc dut (
    .clk(clk), .rstN(rstN), .start(start),
    .inW(inW), .inH(inH), .outW(outW), .outH(outH),
    .done(done), .err(err), .hStep(hStep), .vStep(vStep),
    .hBank(hBank), .vBank(vBank), .hMiss(hMiss), .vMiss(vMiss),
    .bypass(bypass)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint stepOf(longint i, longint o);
    longint q = (i << 20) / o;
    return (q > 64'hFFFFFF) ? 64'hFFFFFF : q;
  endfunction

  task automatic bankOf(longint i, longint o, output int b, output bit m);
    longint r = (o * 1000) / i;
    b = 0; m = 1;
    for (int k = 0; k < 8; k++)
      if (m && r >= tLo[k] && r <= tHi[k]) begin b = k; m = 0; end
  endtask

  task automatic checkResults(string tag);
    check({tag, " R2/R3 hStep"}, hStep, expHS);
    check({tag, " R2/R3 vStep"}, vStep, expVS);
    check({tag, " R4 hBank"}, hBank, expHB);
    check({tag, " R4 vBank"}, vBank, expVB);
    check({tag, " R5 hMiss"}, hMiss, expHM);
    check({tag, " R5 vMiss"}, vMiss, expVM);
    check({tag, " R6 bypass"}, bypass, expBy);
  endtask

  // Accept a request and wait for done; checks latency (R7) and results.
  task automatic runCase(string tag, int iw, int ih, int ow, int oh);
    int n = 0;
    int dc;
    @(negedge clk);
    inW = SW'(iw); inH = SW'(ih); outW = SW'(ow); outH = SW'(oh);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    dc = doneCount;
    while (!done && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    expHS = stepOf(iw, ow);
    expVS = stepOf(ih, oh);
    bankOf(iw, ow, expHB, expHM);
    bankOf(ih, oh, expVB, expVM);
    expBy = (iw == ow) && (ih == oh);
    check({tag, " R7 latency"}, n, LAT);
    check({tag, " R8 err low"}, err, 0);
    checkResults(tag);
    @(negedge clk);
    check({tag, " R7 single-cycle done"}, done, 0);
    check({tag, " R7 done count"}, doneCount - dc, 1);
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 hStep", hStep, 0);
    check("R1 vStep", vStep, 0);
    check("R1 hBank", hBank, 0);
    check("R1 vBank", vBank, 0);
    check("R1 miss", {hMiss, vMiss}, 0);
    check("R1 bypass", bypass, 0);
  endtask

  task automatic t_independentAxes();
    // R10: width ratio 500 -> bank 4, height ratio 666 -> bank 3
    runCase("R10 axes", 1920, 1080, 960, 720);
    check("R10 banks differ", (hBank != vBank), 1);
  endtask

  task automatic t_unity();
    runCase("R6 unity", 640, 480, 640, 480);
    check("R6 bypass set", bypass, 1);
  endtask

  task automatic t_halfEqual();
    // R6: only one axis equal, no bypass
    runCase("R6 one axis", 640, 480, 640, 240);
    check("R6 bypass clear", bypass, 0);
  endtask

  task automatic t_boundaries();
    // R4: 900 matches indices 0 and 1, lowest wins; 800 is inclusive low of 1
    runCase("R4 edges", 1000, 1000, 900, 800);
    check("R4 overlap bank0", hBank, 0);
    check("R4 inclusive bank1", vBank, 1);
  endtask

  task automatic t_lowEdge();
    // R4/R5: 125 is inclusive low of bank 7, 124 matches nothing
    runCase("R5 low edge", 1000, 1000, 125, 124);
    check("R4 bank7", hBank, 7);
    check("R5 vMiss", vMiss, 1);
  endtask

  task automatic t_outOfRange();
    // R5: upscale gives ratio 2000, strong downscale gives 100
    runCase("R5 out of range", 100, 1000, 200, 100);
    check("R5 both miss", {hMiss, vMiss}, 2'b11);
  endtask

  task automatic t_saturate();
    // R3: 8192/256 = 32 exceeds Q4.20 range
    runCase("R3 saturate", 8192, 300, 256, 299);
    check("R3 hStep sat", hStep, 24'hFFFFFF);
  endtask

  task automatic t_zeroAbort();
    longint pHS = expHS, pVS = expVS;
    int pHB = expHB, pVB = expVB;
    bit pHM = expHM, pVM = expVM, pBy = expBy;
    @(negedge clk);
    inW = 14'd500; inH = 14'd500; outW = 14'd0; outH = 14'd250;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R8 done", done, 1);
    check("R8 err", err, 1);
    expHS = pHS; expVS = pVS; expHB = pHB; expVB = pVB;
    expHM = pHM; expVM = pVM; expBy = pBy;
    checkResults("R8 held");
    @(negedge clk);
    check("R8 done drops", done, 0);
    check("R8 err drops", err, 0);
    repeat (40) @(negedge clk);
    checkResults("R8 still held");
  endtask

  task automatic t_busyIgnore();
    int n = 0;
    int dc;
    @(negedge clk);
    inW = 14'd800; inH = 14'd600; outW = 14'd400; outH = 14'd300;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    dc = doneCount;
    repeat (5) begin @(posedge clk); n++; @(negedge clk); end
    inW = 14'd100; inH = 14'd100; outW = 14'd100; outH = 14'd100;
    start = 1'b1;
    @(posedge clk); n++;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    expHS = stepOf(800, 400); expVS = stepOf(600, 300);
    bankOf(800, 400, expHB, expHM);
    bankOf(600, 300, expVB, expVM);
    expBy = 0;
    check("R9 latency of first request", n, LAT);
    checkResults("R9 first request kept");
    repeat (45) @(negedge clk);
    check("R9 no extra done", doneCount - dc, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_independentAxes();
    t_unity();
    t_halfEqual();
    t_boundaries();
    t_lowEdge();
    t_outOfRange();
    t_saturate();
    t_zeroAbort();
    t_busyIgnore();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule